// File: doc/BRIEF.md
# Reloading Down-Counter Interval Timer

This block is a single channel of a periodic interval timer. It runs on the system clock and advances only on a separate count-clock enable pulse, one system-clock cycle wide. A start strobe arms the channel. The channel does not begin counting at the strobe. It waits for the next count-clock pulse, and that pulse forms a start trigger. The start trigger copies the stored period into the down-counter. It can also raise an interrupt when the start-interrupt mode input is high.

After the start trigger, each count-clock pulse decrements the counter. A pulse that finds the counter at zero reloads the stored period and raises an interrupt. Counting then goes on without a break, so every interval lasts period+1 count-clock pulses. A stop strobe freezes the channel. Software reads the live count and receives interrupt and start-trigger pulses one system-clock cycle wide.

Top module: `interval_tmr`

## Requirements
- R1: After reset the count output reads FFFFh, `running_o` is 0, and neither `start_trig_o` nor `irq_o` is asserted.
- R2: A start strobe sets `running_o` to 1 on the next cycle. The count keeps its previous value until a count-clock pulse arrives in a later cycle. A count-clock pulse in the same cycle as the strobe does not act as the start trigger.
- R3: The first count-clock pulse after the channel is armed loads the stored period into the count. In the following cycle it asserts `start_trig_o` for exactly one cycle.
- R4: At the start trigger, `irq_o` is asserted in the same cycle as `start_trig_o` when `irq_mode_i` is 1. It is not asserted when `irq_mode_i` is 0.
- R5: While running, each count-clock pulse lowers the count by one. Cycles without a count-clock pulse leave it unchanged.
- R6: A count-clock pulse that finds the count at 0000h reloads the stored period and asserts `irq_o` for one cycle. The count sequence is P, P−1, …, 0, P, so an interval spans P+1 pulses. With P = 0, every pulse produces an interrupt.
- R7: `start_trig_o` and `irq_o` are one system-clock cycle wide for each event that causes them.
- R8: A stop strobe clears `running_o` on the next cycle. After that, the count holds its value and no interrupt or start trigger appears, whatever count-clock pulses arrive.
- R9: A period write (`period_we_i` with `period_i`) changes no running count. The new value is used at the next reload or start trigger. A load in the same cycle as a write uses the old value.
- R10: A start strobe while already running re-arms the channel. The next count-clock pulse gives a fresh start trigger and reloads the period.
- R11: A stop and a start strobe in the same cycle act as a stop. The priority order is stop, then start, then the count-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, arms or re-arms the channel |
| stop_i | input | 1 | Stop strobe, disarms the channel |
| period_we_i | input | 1 | Period register write enable |
| period_i | input | CNT_W | Period write data |
| irq_mode_i | input | 1 | 1: also interrupt at the start trigger |
| cnt_tick_i | input | 1 | Count-clock enable pulse |
| count_o | output | CNT_W | Current count value |
| running_o | output | 1 | Channel enable flag |
| start_trig_o | output | 1 | One-cycle start trigger pulse |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The count-clock pulses are applied in several patterns: sparse, with idle cycles between them, and back to back every cycle. The sparse pattern separates counting on pulses from counting on system clocks. The back-to-back pattern, combined with a period of zero, shows whether the reload interrupt repeats on every pulse. Start strobes are applied while idle, while running, in the same cycle as a pulse, and together with a stop; these cases tell the deferred start, the re-arm and the priority order apart. Period writes placed mid-interval show whether a new value leaks into the running count before the reload.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    // Control state of the channel: enable flag, armed-but-not-triggered
    // flag, and the two registered one-cycle pulses.
    typedef struct packed {
        logic en;
        logic pend;
        logic trig;
        logic st_irq;
    } itmr_ctrl_t;

endpackage

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
    import itmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic tick_i,
    input  logic irq_mode_i,
    output logic en_o,
    output logic load_o,
    output logic run_tick_o,
    output logic trig_o,
    output logic st_irq_o
);

    itmr_ctrl_t st_d, st_q;
    logic       cmd_idle;

    // Priority: stop, then start, then count-clock pulse.
    assign cmd_idle = !stop_i && !start_i;

    always_comb begin
        st_d        = st_q;
        st_d.trig   = 1'b0;
        st_d.st_irq = 1'b0;
        load_o      = 1'b0;
        run_tick_o  = 1'b0;
        if (stop_i) begin
            st_d.en   = 1'b0;
            st_d.pend = 1'b0;
        end else if (start_i) begin
            st_d.en   = 1'b1;
            st_d.pend = 1'b1;
        end else if (tick_i && st_q.en) begin
            if (st_q.pend) begin
                st_d.pend   = 1'b0;
                st_d.trig   = 1'b1;
                st_d.st_irq = irq_mode_i;
                load_o      = cmd_idle;
            end else begin
                run_tick_o  = cmd_idle;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o     = st_q.en;
    assign trig_o   = st_q.trig;
    assign st_irq_o = st_q.st_irq;

    // R7: a start trigger never lasts two cycles
    p_trig_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R4: the start interrupt only appears with its start trigger
    p_start_irq_with_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_irq_o |-> trig_o);

    // R8 / R11: a stop strobe always leaves the channel disabled
    p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !en_o);

    // R2: a start strobe arms the channel but is not itself a trigger
    p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> (en_o && !trig_o));

endmodule

// File: rtl/itmr_cnt.sv
module itmr_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_tick_i,
    input  logic             per_we_i,
    input  logic [CNT_W-1:0] per_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_irq_o
);

    localparam logic [CNT_W-1:0] CNT_RST = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic             zirq;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_zero;

    assign at_zero = (st_q.cnt == '0);

    always_comb begin
        st_d      = st_q;
        st_d.zirq = 1'b0;
        if (per_we_i) begin
            st_d.per = per_i;
        end
        if (load_i) begin
            st_d.cnt = st_q.per;
        end else if (run_tick_i) begin
            if (at_zero) begin
                st_d.cnt  = st_q.per;
                st_d.zirq = 1'b1;
            end else begin
                st_d.cnt  = st_q.cnt - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= CNT_RST;
            st_q.per  <= CNT_RST;
            st_q.zirq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o    = st_q.cnt;
    assign zero_irq_o = st_q.zirq;

    // R5: without a load or a running pulse the count does not move
    p_hold_no_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !run_tick_i) |=> $stable(count_o));

    // R5: a running pulse on a nonzero count lowers it by one
    p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick_i && count_o != '0) |=> (count_o == $past(count_o) - CNT_ONE));

    // R6: a pulse at zero reloads and flags the interrupt
    p_zero_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick_i && count_o == '0) |=> (zero_irq_o && count_o == $past(st_q.per)));

    // R3 / R9: a start load takes the period held before this cycle's write
    p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(st_q.per) && !zero_irq_o));

endmodule

// File: rtl/interval_tmr.sv
module interval_tmr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             period_we_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             irq_mode_i,
    input  logic             cnt_tick_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             start_trig_o,
    output logic             irq_o
);

    logic load_w;
    logic run_tick_w;
    logic st_irq_w;
    logic zero_irq_w;

    itmr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .stop_i     (stop_i),
        .tick_i     (cnt_tick_i),
        .irq_mode_i (irq_mode_i),
        .en_o       (running_o),
        .load_o     (load_w),
        .run_tick_o (run_tick_w),
        .trig_o     (start_trig_o),
        .st_irq_o   (st_irq_w)
    );

    itmr_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_w),
        .run_tick_i (run_tick_w),
        .per_we_i   (period_we_i),
        .per_i      (period_i),
        .count_o    (count_o),
        .zero_irq_o (zero_irq_w)
    );

    assign irq_o = st_irq_w | zero_irq_w;

    // R8: a disabled channel raises no interrupt
    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> (!irq_o && !start_trig_o));

    // R6 / R4: the start and reload interrupt sources never coincide
    p_irq_sources_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_irq_w && zero_irq_w));

    // R3: a start trigger follows a count-clock pulse
    p_trig_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_trig_o |-> $past(cnt_tick_i));

endmodule

// File: tb/interval_tmr_test.sv
module interval_tmr_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic        period_we_i = 1'b0;
    logic [15:0] period_i = '0;
    logic        irq_mode_i = 1'b0;
    logic        cnt_tick_i = 1'b0;
    logic [15:0] count_o;
    logic        running_o;
    logic        start_trig_o;
    logic        irq_o;

    always #2.5 clk = ~clk;

    interval_tmr uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .period_we_i  (period_we_i),
        .period_i     (period_i),
        .irq_mode_i   (irq_mode_i),
        .cnt_tick_i   (cnt_tick_i),
        .count_o      (count_o),
        .running_o    (running_o),
        .start_trig_o (start_trig_o),
        .irq_o        (irq_o)
    );

    typedef struct {
        int   cyc;
        logic trig;
        logic irq;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    logic  mon_on = 1'b0;
    string cur_req = "R1";

    // Reference state derived from the requirements
    logic [15:0] m_cnt = 16'hFFFF;
    logic [15:0] m_per = 16'hFFFF;
    logic        m_en = 1'b0;
    logic        m_pend = 1'b0;

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Driver: applies one cycle of stimulus, advances the model, pushes
    // the pulses it expects, then compares the count and enable flag.
    task automatic step(input logic tk, input logic st, input logic sp,
                        input logic we, input logic [15:0] pd);
        logic et;
        logic ei;
        cnt_tick_i  = tk;
        start_i     = st;
        stop_i      = sp;
        period_we_i = we;
        period_i    = pd;
        @(posedge clk);
        cyc++;
        et = 1'b0;
        ei = 1'b0;
        if (sp) begin
            m_en   = 1'b0;
            m_pend = 1'b0;
        end else if (st) begin
            m_en   = 1'b1;
            m_pend = 1'b1;
        end else if (tk && m_en) begin
            if (m_pend) begin
                m_pend = 1'b0;
                m_cnt  = m_per;
                et     = 1'b1;
                ei     = irq_mode_i;
            end else if (m_cnt == 16'h0000) begin
                m_cnt = m_per;
                ei    = 1'b1;
            end else begin
                m_cnt = m_cnt - 16'd1;
            end
        end
        if (we) m_per = pd;
        if (et || ei) exp_q.push_back('{cyc: cyc, trig: et, irq: ei});
        @(negedge clk);
        check(count_o == m_cnt, cur_req, "count", int'(count_o), int'(m_cnt));
        check(running_o == m_en, cur_req, "running", int'(running_o), int'(m_en));
        cnt_tick_i  = 1'b0;
        start_i     = 1'b0;
        stop_i      = 1'b0;
        period_we_i = 1'b0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
            for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
        end
    endtask

    // Monitor: pops the scoreboard whenever a pulse is due or seen (R7)
    always @(negedge clk) begin
        exp_t e;
        logic have;
        if (mon_on) begin
            have = (exp_q.size() > 0) && (exp_q[0].cyc == cyc);
            if (have || start_trig_o || irq_o) begin
                if (have) e = exp_q.pop_front();
                else      e = '{cyc: cyc, trig: 1'b0, irq: 1'b0};
                check(start_trig_o == e.trig, cur_req, "start_trig", int'(start_trig_o), int'(e.trig));
                check(irq_o == e.irq, cur_req, "irq", int'(irq_o), int'(e.irq));
            end
        end
    end

    task automatic finish_run;
        check(exp_q.size() == 0, "R7", "pending pulses", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(count_o == 16'hFFFF, "R1", "count", int'(count_o), 16'hFFFF);
        check(running_o == 1'b0, "R1", "running", int'(running_o), 0);
        check(start_trig_o == 1'b0, "R1", "start_trig", int'(start_trig_o), 0);
        check(irq_o == 1'b0, "R1", "irq", int'(irq_o), 0);
        mon_on = 1'b1;

        cur_req = "R9";
        step(1'b0, 1'b0, 1'b0, 1'b1, 16'd3);

        // R2: armed, count waits for a pulse; a pulse with the strobe is ignored
        cur_req = "R2";
        irq_mode_i = 1'b0;
        step(1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 16'h0);

        // R3 / R4: first pulse loads period, trigger without interrupt
        cur_req = "R3";
        ticks(1, 2);

        // R5: sparse pulses decrement one each
        cur_req = "R5";
        ticks(2, 3);

        // R6: reach zero, reload with interrupt; two full intervals
        cur_req = "R6";
        ticks(9, 1);

        // R9: mid-interval period write waits for the reload
        cur_req = "R9";
        step(1'b1, 1'b0, 1'b0, 1'b1, 16'd5);
        ticks(6, 0);

        // R10: re-arm while running
        cur_req = "R10";
        step(1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
        ticks(3, 1);

        // R8: stop freezes count and silences pulses
        cur_req = "R8";
        step(1'b1, 1'b0, 1'b1, 1'b0, 16'h0);
        ticks(8, 0);

        // R4: start interrupt with mode set
        cur_req = "R4";
        irq_mode_i = 1'b1;
        step(1'b0, 1'b1, 1'b0, 1'b1, 16'd0);
        ticks(1, 1);

        // R6: period 0 with back-to-back pulses, interrupt every pulse
        cur_req = "R6";
        irq_mode_i = 1'b0;
        ticks(5, 0);

        // R11: stop and start together act as stop
        cur_req = "R11";
        step(1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        ticks(3, 0);

        // R9: write and start load in the same cycle uses old value
        cur_req = "R9";
        step(1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
        step(1'b1, 1'b0, 1'b0, 1'b1, 16'd7);
        ticks(3, 0);

        step(1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
        finish_run;
    end

endmodule